// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block collects interrupt events from fifteen sources, numbered 1 to 15, and tells the processor which one to serve next. A rising edge on a source input sets that source's pending bit. The bit stays set until software clears it or the processor acknowledges the level. A mask register can hold back any source. Of the unmasked pending sources, the one with the highest number is presented as a 4-bit interrupt level and as an 8-bit trap type.

Software reaches the block through a small register bus with single-cycle writes and combinational reads. Source n always uses bit n of every register. Its number is also its priority level and the low nibble of its trap type. For testing, software can inject interrupts through a force register. Forcing works only while the test-enable bit of the test-control register is set.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on `irq_src[n]` (1 ≤ n ≤ 15) sets pending bit n at that clock edge. Pending is read at offset 0x48, with source n in bit n. A source held high does not set its bit again after the bit is cleared.
- R2: A pending bit stays set until it is cleared through the clear register or by an acknowledge.
- R3: `irq_level` is the highest-numbered source that is both pending and unmasked. It is 0 when there is no such source.
- R4: `irq_trap` is 0x10 + `irq_level` when the level is non-zero, and 0x00 otherwise. This gives 0x11 for source 1 and 0x1F for source 15.
- R5: The mask register is at offset 0x4C and is readable and writable. A 1 in bit n stops source n from being presented, but its pending bit is still recorded. Clearing the mask bit lets the source be presented again.
- R6: Writing a word to the clear register (offset 0x50) removes each pending bit whose written bit is 1. Written 0 bits change nothing. The clear register reads as 0.
- R7: Writing a word to the force register (offset 0x54) sets each pending bit whose written bit is 1, but only while test-control bit 19 is 1. Test control is at offset 0xD0 and reads back as 0x80000 or 0. While bit 19 is 0, force writes have no effect.
- R8: With `ack_valid` high, pending bit `ack_level` is cleared at the clock edge. An acknowledge of level 0 has no effect.
- R9: A new event in the same cycle as a clear or an acknowledge of the same bit leaves the bit set. The event can be a rising edge or a force.
- R10: Bit 0 of every register reads as 0 and ignores writes and `irq_src[0]`. Writes to the pending offset have no effect.
- R11: After reset, pending is 0, mask is 0xFFFE (all masked), test control is 0, and `irq_level` and `irq_trap` are 0.
- R12: Reads of any offset other than pending, mask, clear, force and test control return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 16 | Source event lines, bit n for source n; bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| ack_valid | input | 1 | Processor accepted an interrupt this cycle |
| ack_level | input | 4 | Level being accepted |
| irq_level | output | 4 | Highest unmasked pending source, 0 when none |
| irq_trap | output | 8 | Trap type for the presented level |

## Verification
The bench aims at the collisions in the pending bits. A clear and a rising edge of the same bit in one cycle must leave the bit set. The same holds for an acknowledge and an edge. A design that gave clear priority would lose that event without any trace. A source held high across a clear must not set its bit again, or a level-triggered design would keep interrupting. The bench also forces a bit while test enable is off, which a design missing the gate would accept. It checks the priority winners at sources 1 and 15, where an off-by-one encoder would report the wrong level or trap. It writes to bit 0 and to the read-only pending offset, where a careless decoder would show spurious state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC     = 15;
  localparam int unsigned LVLW     = $clog2(NSRC + 1);
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 8;
  localparam int unsigned TRW      = 8;
  localparam int unsigned TEST_BIT = 19;

  localparam logic [AW-1:0]  OFS_PEND = 8'h48;
  localparam logic [AW-1:0]  OFS_MASK = 8'h4C;
  localparam logic [AW-1:0]  OFS_CLR  = 8'h50;
  localparam logic [AW-1:0]  OFS_FRC  = 8'h54;
  localparam logic [AW-1:0]  OFS_TEST = 8'hD0;
  localparam logic [TRW-1:0] TRAP_BASE = 8'h10;

  typedef logic [NSRC:0]   vec_t;
  typedef logic [LVLW-1:0] lvl_t;

  // Highest set bit among 1..NSRC, 0 if none.
  function automatic lvl_t top_level(input vec_t act);
    lvl_t l;
    l = '0;
    for (int i = 1; i <= int'(NSRC); i++) begin
      if (act[i]) l = LVLW'(i);
    end
    return l;
  endfunction

  // Trap type: base plus level, or zero when nothing is presented.
  function automatic logic [TRW-1:0] trap_of(input lvl_t l);
    return (l == '0) ? '0 : TRAP_BASE + TRW'(l);
  endfunction

  // One-hot bit for a level; level 0 and out-of-range levels map to nothing.
  function automatic vec_t onehot_lvl(input lvl_t l);
    vec_t v;
    v = '0;
    if (l != '0 && int'(l) <= int'(NSRC)) v[l] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t src,
  input  vec_t clr_vec,
  input  vec_t frc_vec,
  input  vec_t ack_vec,
  output vec_t src_rise,
  output vec_t pend
);
  vec_t src_q;
  vec_t pend_nxt;

  always_comb begin
    src_rise    = src & ~src_q;
    src_rise[0] = 1'b0;
    // New events win over removal in the same cycle.
    pend_nxt    = src_rise | frc_vec | (pend & ~(clr_vec | ack_vec));
    pend_nxt[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= pend_nxt;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  vec_t          pend,
  output logic [DW-1:0] bus_rdata,
  output vec_t          mask,
  output logic          test_en,
  output vec_t          clr_vec,
  output vec_t          frc_vec
);
  logic wr_hit;
  vec_t wvec;
  logic unused_wdata;

  assign wr_hit       = bus_sel & bus_wr;
  assign wvec         = {bus_wdata[NSRC:1], 1'b0};
  assign unused_wdata = ^bus_wdata;

  assign clr_vec = (wr_hit && bus_addr == OFS_CLR) ? wvec : '0;
  // Force is gated by the test-enable value held before this write.
  assign frc_vec = (wr_hit && bus_addr == OFS_FRC && test_en) ? wvec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= {{NSRC{1'b1}}, 1'b0};
      test_en <= 1'b0;
    end else if (wr_hit) begin
      if (bus_addr == OFS_MASK) mask    <= wvec;
      if (bus_addr == OFS_TEST) test_en <= bus_wdata[TEST_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_PEND: bus_rdata = DW'(pend);
        OFS_MASK: bus_rdata = DW'(mask);
        OFS_TEST: bus_rdata = DW'(test_en) << TEST_BIT;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  vec_t           pend,
  input  vec_t           mask,
  output vec_t           active,
  output lvl_t           level,
  output logic [TRW-1:0] trap
);
  assign active = pend & ~mask;
  assign level  = top_level(active);
  assign trap   = trap_of(level);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_src,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ack_valid,
  input  logic [3:0]  ack_level,
  output logic [3:0]  irq_level,
  output logic [7:0]  irq_trap
);
  vec_t pend, mask, active, src_rise, clr_vec, frc_vec, ack_vec;
  logic test_en;

  assign ack_vec = ack_valid ? onehot_lvl(ack_level) : '0;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend),
    .bus_rdata(bus_rdata), .mask(mask), .test_en(test_en),
    .clr_vec(clr_vec), .frc_vec(frc_vec)
  );

  irqc_pending u_pend (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .clr_vec(clr_vec),
    .frc_vec(frc_vec), .ack_vec(ack_vec), .src_rise(src_rise), .pend(pend)
  );

  irqc_prio u_prio (
    .pend(pend), .mask(mask), .active(active),
    .level(irq_level), .trap(irq_trap)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input vec_t           pend,
  input vec_t           mask,
  input vec_t           active,
  input vec_t           src_rise,
  input vec_t           clr_vec,
  input vec_t           frc_vec,
  input vec_t           ack_vec,
  input lvl_t           level,
  input logic [TRW-1:0] trap
);
  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise != '0) |=> ((pend & $past(src_rise)) == $past(src_rise)));

  assert_pend_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr_vec | ack_vec) & ~pend) == '0));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (level == '0));

  assert_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> ((active >> level) == vec_t'(1)));

  assert_trap_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> (trap[7:4] == 4'h1 && trap[3:0] == level));

  assert_trap_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (trap == '0));

  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> !mask[level]);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend & $past(clr_vec & ~(src_rise | frc_vec))) == '0));

  assert_ack_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((pend & $past(ack_vec & ~(src_rise | frc_vec))) == '0));

  assert_bit0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] == 1'b0) && (mask[0] == 1'b0));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .active(active),
  .src_rise(src_rise), .clr_vec(clr_vec), .frc_vec(frc_vec),
  .ack_vec(ack_vec), .level(irq_level), .trap(irq_trap)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = '0;
  logic [3:0]  irq_level;
  logic [7:0]  irq_trap;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_PEND = 8'h48, A_MASK = 8'h4C, A_CLR = 8'h50,
                         A_FRC = 8'h54, A_TEST = 8'hD0;

  always #2 clk = ~clk;

  irqc_top u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse(input logic [15:0] bits);
    irq_src = irq_src | bits; tick();
    irq_src = irq_src & ~bits; tick();
  endtask

  task automatic t_reset();
    chk_reg("R11 pending", A_PEND, 32'h0);
    chk_reg("R11 mask", A_MASK, 32'hFFFE);
    chk_reg("R11 test", A_TEST, 32'h0);
    chk("R11 level", {28'h0, irq_level}, 32'h0);
    chk("R11 trap", {24'h0, irq_trap}, 32'h0);
  endtask

  task automatic t_latch();
    wr(A_MASK, 32'h0);
    irq_src[5] = 1'b1; tick();
    chk_reg("R1 edge sets", A_PEND, 32'h20);
    chk("R4 trap 5", {24'h0, irq_trap}, 32'h15);
    repeat (3) tick();
    chk_reg("R2 held pending", A_PEND, 32'h20);
    wr(A_CLR, 32'h20);
    tick();
    chk_reg("R1 level held no reset", A_PEND, 32'h0);
    irq_src[5] = 1'b0; tick();
  endtask

  task automatic t_prio();
    pulse(16'h1008);
    chk("R3 level 12", {28'h0, irq_level}, 32'd12);
    pulse(16'h0200);
    chk("R3 level still 12", {28'h0, irq_level}, 32'd12);
    wr(A_CLR, 32'h0);
    chk_reg("R6 zero clear", A_PEND, 32'h1208);
    chk_reg("R6 clear reads 0", A_CLR, 32'h0);
    wr(A_CLR, 32'h1000);
    chk("R3 level 9", {28'h0, irq_level}, 32'd9);
    wr(A_CLR, 32'hFFFF);
    chk("R3 none", {28'h0, irq_level}, 32'd0);
    pulse(16'h0002);
    chk("R4 trap 1", {24'h0, irq_trap}, 32'h11);
    pulse(16'h8000);
    chk("R4 trap 15", {24'h0, irq_trap}, 32'h1F);
    wr(A_CLR, 32'hFFFF);
    chk("R4 trap idle", {24'h0, irq_trap}, 32'h0);
  endtask

  task automatic t_mask();
    wr(A_MASK, 32'h80);
    chk_reg("R5 mask readback", A_MASK, 32'h80);
    pulse(16'h0080);
    chk_reg("R5 masked still pending", A_PEND, 32'h80);
    chk("R5 masked hidden", {28'h0, irq_level}, 32'd0);
    pulse(16'h0004);
    chk("R5 lower shown", {28'h0, irq_level}, 32'd2);
    wr(A_MASK, 32'h0);
    chk("R5 unmask", {28'h0, irq_level}, 32'd7);
    wr(A_CLR, 32'hFFFF);
  endtask

  task automatic t_force();
    wr(A_FRC, 32'h400);
    chk_reg("R7 force gated", A_PEND, 32'h0);
    wr(A_TEST, 32'h80000);
    chk_reg("R7 test readback", A_TEST, 32'h80000);
    chk_reg("R7 force reads 0", A_FRC, 32'h0);
    wr(A_FRC, 32'h400);
    chk_reg("R7 force sets", A_PEND, 32'h400);
    chk("R7 forced level", {28'h0, irq_level}, 32'd10);
    wr(A_CLR, 32'hFFFF);
  endtask

  task automatic t_ack();
    pulse(16'h4010);
    ack_valid = 1'b1; ack_level = 4'd14; tick();
    ack_valid = 1'b0;
    chk_reg("R8 ack 14", A_PEND, 32'h10);
    ack_valid = 1'b1; ack_level = 4'd0; tick();
    ack_valid = 1'b0;
    chk_reg("R8 ack 0 no effect", A_PEND, 32'h10);
    ack_valid = 1'b1; ack_level = 4'd4; tick();
    ack_valid = 1'b0;
    chk("R8 ack 4 level", {28'h0, irq_level}, 32'd0);
  endtask

  task automatic t_collide();
    pulse(16'h0040);
    irq_src[6] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h40;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    irq_src[6] = 1'b0;
    chk_reg("R9 edge beats clear", A_PEND, 32'h40);
    tick();
    irq_src[6] = 1'b1; ack_valid = 1'b1; ack_level = 4'd6; tick();
    irq_src[6] = 1'b0; ack_valid = 1'b0;
    chk_reg("R9 edge beats ack", A_PEND, 32'h40);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FRC; bus_wdata = 32'h40;
    ack_valid = 1'b1; ack_level = 4'd6; tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; ack_valid = 1'b0;
    chk_reg("R9 force beats ack", A_PEND, 32'h40);
    wr(A_CLR, 32'hFFFF);
  endtask

  task automatic t_bit0();
    pulse(16'h0001);
    chk_reg("R10 src0 ignored", A_PEND, 32'h0);
    wr(A_FRC, 32'h1);
    chk_reg("R10 force bit0", A_PEND, 32'h0);
    wr(A_MASK, 32'hFFFF);
    chk_reg("R10 mask bit0", A_MASK, 32'hFFFE);
    wr(A_MASK, 32'h0);
    wr(A_PEND, 32'h100);
    chk_reg("R10 pending read-only", A_PEND, 32'h0);
    chk_reg("R12 unmapped", 8'h60, 32'h0);
    chk_reg("R12 unmapped 44", 8'h44, 32'h0);
    wr(A_TEST, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_prio();
    t_mask();
    t_force();
    t_ack();
    t_collide();
    t_bit0();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule